// File: doc/BRIEF.md
# OFDM Preamble-to-Payload Transmit Sequencer

This block produces the transmit sample stream for one OFDM packet. After a start pulse it plays out a fixed 320-entry complex preamble held in an internal sample memory. It then switches its output over to the payload samples offered by an upstream IFFT stage, whose stream begins with the 16-sample cyclic prefix of the first symbol. Each sample is a signed 16-bit I/Q pair with 15 fractional bits. The whole datapath moves only on a sample-rate clock enable that is high for a single clock and recurs no faster than every 4 clocks. Between enables every output is held.

The preamble address counter compares its value against the final address. That comparison turns true one sample before the final preamble entry has left the memory pipeline. The sequencer therefore routes the early select through the same registered read-enable path that the memory data takes. The payload select, and the `done` flag that mirrors it, switch on the update that carries the final entry, so no preamble entry is lost or repeated. The payload enters through a valid/ready handshake. Ready is offered only on an enable cycle in which the payload path is selected. Holding valid low only stalls the stream: no sample is lost, none is repeated, and no output strobe is produced.

The memory is written through a plain write port before a packet is started.

Top module: `ofdm_tx_seq`

## Requirements
- R1: While reset is held and directly after it, `out_valid`, `done` and `pay_ready` are 0, even with `ce` high.
- R2: After a start pulse, the first enable tick reads memory entry 0. The second tick outputs entry 0. Ticks 2 through 321 then output entries 0..319 in address order, each exactly once.
- R3: `done` rises on the output update of tick 321, which carries entry 319. It stays high until the next start, and no preamble entry is output while it is high.
- R4: `pay_ready` is high only in a cycle where `ce` is high and `done` is already high (so from tick 322 on). It is never high during the preamble.
- R5: A payload sample accepted on a tick (`pay_valid` and `pay_ready` both high) appears on `out_i`/`out_q` with `out_valid` in the next cycle. With valid held high, payload sample 0 follows entry 319 on the very next tick, 322, and the payload keeps its order.
- R6: `out_valid` is high for exactly one cycle after each enable tick that moved a sample. `out_i`/`out_q` change only after an enable tick.
- R7: On a tick with `pay_ready` high and `pay_valid` low, no strobe is produced. The next accepted sample is the one that was pending, so none is skipped.
- R8: A start pulse restarts the sequence at entry 0 at any time, including during the preamble or the payload. `done` is 0 in the cycle after the start.
- R9: The behaviour of R2 through R7 holds for any enable period of 4 clocks or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce | input | 1 | Sample-rate enable, one clock wide, period of at least 4 clocks |
| start | input | 1 | One-clock pulse that begins a packet |
| pre_we | input | 1 | Preamble memory write strobe |
| pre_waddr | input | 9 | Preamble memory write address (0..319) |
| pre_wr_i | input | 16 | Preamble I value to write |
| pre_wr_q | input | 16 | Preamble Q value to write |
| pay_valid | input | 1 | Upstream payload sample is present |
| pay_ready | output | 1 | Payload sample accepted this cycle |
| pay_i | input | 16 | Payload I sample, signed Q1.15 |
| pay_q | input | 16 | Payload Q sample, signed Q1.15 |
| out_valid | output | 1 | One-cycle strobe marking a new output sample |
| out_i | output | 16 | Output I sample, signed Q1.15 |
| out_q | output | 16 | Output Q sample, signed Q1.15 |
| done | output | 1 | Preamble finished and payload path selected |

## Verification
Suppose the select pipeline is one stage too short. Then `done` and `pay_ready` appear one tick early and entry 319 never reaches the output. Suppose instead it is one stage too long. Then entry 319 is emitted twice, or a strobe is missing at tick 322. Either fault shows at the ports within one enable period of the preamble's end. An address counter that starts at the wrong place, or one that skips or stalls, shows on the very first strobe or on the first strobe that carries a wrong value, because every memory entry holds a distinct value. A payload handshake that drops or repeats a sample shows as a break in the payload ramp on the strobe that follows the stalled tick.

// File: rtl/ofdm_tx_pkg.sv
package ofdm_tx_pkg;
  localparam int SAMP_W = 16;

  typedef struct packed {
    logic signed [SAMP_W-1:0] i;
    logic signed [SAMP_W-1:0] q;
  } iq_t;
endpackage

// File: rtl/ofdm_pre_rom.sv
module ofdm_pre_rom
  import ofdm_tx_pkg::*;
#(
  parameter int DEPTH = 320,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  iq_t           wdata,
  input  logic          rd_en,
  input  logic [AW-1:0] raddr,
  output iq_t           rdata
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  iq_t mem [DEPTH];

  // One-cycle registered read; the read only happens on enabled ticks.
  always_ff @(posedge clk) begin
    if (we && (waddr <= LAST)) mem[waddr] <= wdata;
    if (rd_en) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ofdm_seq_ctrl.sv
module ofdm_seq_ctrl #(
  parameter int DEPTH = 320,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          start,
  output logic          rd_en,
  output logic [AW-1:0] addr,
  output logic          pre_vld,
  output logic          pay_sel
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          active;
  logic          last_rd;
  logic [AW-1:0] addr_q;
  logic          at_end;
  logic          sel_early_q;
  logic          sel_q;

  // Address comparison: true as soon as the address reaches the final entry,
  // one sample ahead of that entry leaving the memory.
  assign at_end = (addr_q == LAST);
  assign rd_en  = ce && active && !last_rd && !start;
  assign addr   = addr_q;
  assign pay_sel = sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active      <= 1'b0;
      last_rd     <= 1'b0;
      addr_q      <= '0;
      sel_early_q <= 1'b0;
      sel_q       <= 1'b0;
      pre_vld     <= 1'b0;
    end else if (start) begin
      active      <= 1'b1;
      last_rd     <= 1'b0;
      addr_q      <= '0;
      sel_early_q <= 1'b0;
      sel_q       <= 1'b0;
      pre_vld     <= 1'b0;
    end else if (ce && active) begin
      if (!last_rd) begin
        if (at_end) last_rd <= 1'b1;
        else        addr_q  <= addr_q + 1'b1;
      end
      // Registered read-enable path: memory data is valid one tick after
      // the read, and the select is delayed by the same amount plus the
      // output register so it tracks data rather than address.
      pre_vld     <= rd_en;
      sel_early_q <= at_end;
      sel_q       <= sel_early_q;
    end
  end
endmodule

// File: rtl/ofdm_out_mux.sv
module ofdm_out_mux
  import ofdm_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic start,
  input  logic pay_sel,
  input  logic pre_vld,
  input  iq_t  pre_data,
  input  logic pay_valid,
  input  iq_t  pay_data,
  output logic pay_ready,
  output iq_t  out_data,
  output logic out_valid
);
  assign pay_ready = ce && pay_sel && !start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (ce && !start) begin
        if (pay_sel) begin
          if (pay_valid) begin
            out_data  <= pay_data;
            out_valid <= 1'b1;
          end
        end else if (pre_vld) begin
          out_data  <= pre_data;
          out_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ofdm_tx_seq.sv
module ofdm_tx_seq
  import ofdm_tx_pkg::*;
#(
  parameter int PRE_LEN = 320,
  parameter int AW      = $clog2(PRE_LEN)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ce,
  input  logic                     start,
  input  logic                     pre_we,
  input  logic [AW-1:0]            pre_waddr,
  input  logic signed [SAMP_W-1:0] pre_wr_i,
  input  logic signed [SAMP_W-1:0] pre_wr_q,
  input  logic                     pay_valid,
  output logic                     pay_ready,
  input  logic signed [SAMP_W-1:0] pay_i,
  input  logic signed [SAMP_W-1:0] pay_q,
  output logic                     out_valid,
  output logic signed [SAMP_W-1:0] out_i,
  output logic signed [SAMP_W-1:0] out_q,
  output logic                     done
);
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic          pre_vld;
  logic          pay_sel;
  iq_t           wr_data;
  iq_t           rom_data;
  iq_t           pay_data;
  iq_t           out_data;

  assign wr_data  = '{i: pre_wr_i, q: pre_wr_q};
  assign pay_data = '{i: pay_i, q: pay_q};
  assign out_i    = out_data.i;
  assign out_q    = out_data.q;
  assign done     = pay_sel;

  ofdm_pre_rom #(.DEPTH(PRE_LEN), .AW(AW)) u_rom (
    .clk   (clk),
    .we    (pre_we),
    .waddr (pre_waddr),
    .wdata (wr_data),
    .rd_en (rd_en),
    .raddr (rd_addr),
    .rdata (rom_data)
  );

  ofdm_seq_ctrl #(.DEPTH(PRE_LEN), .AW(AW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce      (ce),
    .start   (start),
    .rd_en   (rd_en),
    .addr    (rd_addr),
    .pre_vld (pre_vld),
    .pay_sel (pay_sel)
  );

  ofdm_out_mux u_mux (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce        (ce),
    .start     (start),
    .pay_sel   (pay_sel),
    .pre_vld   (pre_vld),
    .pre_data  (rom_data),
    .pay_valid (pay_valid),
    .pay_data  (pay_data),
    .pay_ready (pay_ready),
    .out_data  (out_data),
    .out_valid (out_valid)
  );
endmodule

// File: rtl/ofdm_tx_seq_chk.sv
module ofdm_tx_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ce,
  input logic        start,
  input logic        pay_valid,
  input logic        pay_ready,
  input logic [15:0] pay_i,
  input logic [15:0] pay_q,
  input logic        out_valid,
  input logic [15:0] out_i,
  input logic [15:0] out_q,
  input logic        done,
  input logic        pre_vld
);
  p_ready_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pay_ready |-> (ce && done));

  p_strobe_after_ce_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(ce));

  p_hold_between_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ce) |-> ($stable(out_i) && $stable(out_q)));

  p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);

  p_done_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  p_no_pre_after_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !pre_vld);

  p_pay_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_valid && pay_ready) |=>
      (out_valid && out_i == $past(pay_i) && out_q == $past(pay_q)));
endmodule

bind ofdm_tx_seq ofdm_tx_seq_chk u_chk (.*);

// File: tb/sim_ofdm_tx_seq.sv
module sim_ofdm_tx_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NPRE       = 320;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               ce, start, pre_we, pay_valid;
  logic [8:0]         pre_waddr;
  logic signed [15:0] pre_wr_i, pre_wr_q, pay_i, pay_q;
  logic               pay_ready, out_valid, done;
  logic signed [15:0] out_i, out_q;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ofdm_tx_seq u0 (
    .clk(clk), .rst_n(rst_n), .ce(ce), .start(start),
    .pre_we(pre_we), .pre_waddr(pre_waddr), .pre_wr_i(pre_wr_i), .pre_wr_q(pre_wr_q),
    .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_i(pay_i), .pay_q(pay_q),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .done(done)
  );

  function automatic logic signed [15:0] exp_pre_i(int k); return 16'(k*3 - 400); endfunction
  function automatic logic signed [15:0] exp_pre_q(int k); return 16'(1 - k*5);   endfunction
  function automatic logic signed [15:0] exp_pay_i(int n); return 16'(n - 30000); endfunction
  function automatic logic signed [15:0] exp_pay_q(int n); return 16'(n*2 + 7);   endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // One packet: start pulse, then `ticks` enable ticks of period `per`.
  // gap=1 withholds every third payload offer (R7).
  task automatic run_packet(input int per, input bit gap, input int ticks);
    int t = 0;
    int pn = 0;
    int offer = 0;
    int cyc = 0;
    bit ce_n, fire, exp_ov;
    ce = 0; start = 0; pay_valid = 0;
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    chk(done == 1'b0, "R8 done cleared after start", done, 0);
    chk(out_valid == 1'b0, "R8 no strobe after start", out_valid, 0);
    while (t < ticks) begin
      cyc++;
      ce_n = (cyc % per == 0);
      ce = ce_n;
      pay_valid = !(gap && (offer % 3 == 2));
      pay_i = exp_pay_i(pn);
      pay_q = exp_pay_q(pn);
      #1;
      chk(pay_ready == (ce_n && t >= 321), "R4 ready gating", pay_ready, ce_n && t >= 321);
      fire = pay_valid && pay_ready;
      if (ce_n && t >= 321) offer++;
      @(posedge clk);
      if (ce_n) t++;
      @(negedge clk);
      exp_ov = ce_n && ((t >= 2 && t <= 321) || fire);
      chk(out_valid == exp_ov, "R6 R7 strobe timing", out_valid, exp_ov);
      chk(done == (t >= 321), "R3 done timing", done, t >= 321);
      if (out_valid && exp_ov) begin
        if (!fire) begin
          chk(out_i == exp_pre_i(t-2) && out_q == exp_pre_q(t-2), "R2 preamble entry",
              out_i, exp_pre_i(t-2));
        end else begin
          chk(out_i == exp_pay_i(pn) && out_q == exp_pay_q(pn), "R5 payload order",
              out_i, exp_pay_i(pn));
        end
      end
      if (fire) pn++;
    end
    ce = 0;
    pay_valid = 0;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 0; ce = 1; start = 0; pre_we = 0; pay_valid = 1;
    pre_waddr = '0; pre_wr_i = '0; pre_wr_q = '0; pay_i = '0; pay_q = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R1 out_valid in reset", out_valid, 0);
    chk(done == 0, "R1 done in reset", done, 0);
    chk(pay_ready == 0, "R1 ready in reset", pay_ready, 0);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0 && done == 0 && pay_ready == 0, "R1 state after reset",
        {out_valid, done, pay_ready}, 0);
    ce = 0;
    for (int k = 0; k < NPRE; k++) begin
      pre_we = 1; pre_waddr = 9'(k);
      pre_wr_i = exp_pre_i(k); pre_wr_q = exp_pre_q(k);
      @(negedge clk);
    end
    pre_we = 0;
    run_packet(4, 0, 360);   // R2 R3 R5 at minimum period
    run_packet(6, 1, 380);   // R9 longer period, R7 stalls
    run_packet(5, 0, 150);   // R8 cut short mid-preamble
    run_packet(4, 1, 340);   // R8 restart after partial packet
    run_packet(7, 0, 330);   // R9 odd period
    summary();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
  end
endmodule